// File: doc/BRIEF.md
# Fused Multiply-Add Significand Alignment, Add and Normalize Stage

This stage sits between the product generator and the rounder of a double-precision fused multiply-add. It receives the exact product as a sign, a signed exponent and a 128-bit significand whose leading one is at bit 126. It also receives the addend as a sign, a signed exponent and a 53-bit significand with its explicit leading one. The addend is widened onto the same 128-bit frame. The operand with the smaller exponent is shifted right with sticky collection, and the two are then added or subtracted according to their signs.

The result is renormalized so that its leading one is back at bit 126, then narrowed to a 56-bit significand: 53 significand bits followed by guard, round and sticky. The result sign and the adjusted signed exponent come with it. An exact cancellation gives a zero flag whose sign depends on the rounding direction. A zero addend bypasses the addition so the product alone is narrowed. The result is registered one cycle after the input strobe.

Top module: `fma_sig_add_norm`

## Requirements
- R1: The addend significand is placed on the 128-bit frame shifted left by 74, so that its bit 52 lands on bit 126.
- R2: Only the operand with the smaller exponent is shifted right by the exponent difference. Every bit shifted out is ORed into bit 0, and a difference of 128 or more leaves only that sticky bit. The common exponent is the larger of the two.
- R3: When the signs match, the aligned significands are added. A carry into bit 127 causes a one-place sticky right shift and adds 1 to the exponent. The result sign is the common sign.
- R4: When the signs differ, the smaller aligned magnitude is subtracted from the larger. The result takes the product sign when the product magnitude is larger, and the addend sign otherwise.
- R5: An exact-zero difference raises `r_zero` with a significand of 0 and an exponent of 0. The sign is 0, or 1 when `rdn` (round toward minus infinity) is high.
- R6: After a subtraction, the difference is shifted left until its leading one sits at bit 126, and the exponent is reduced by the shift distance. This includes cancellations where the upper 64 bits are empty.
- R7: When `a_zero` is high, the result is the product alone with the product sign and exponent. `a_sign`, `a_exp`, `a_sig` and `rdn` have no effect.
- R8: The normalized 128-bit value is narrowed by a sticky right shift of 71 to 56 bits. For any nonzero result, bit 55 of `r_sig` is 1, and bit 0 holds the OR of all bits discarded.
- R9: Exponents are two's-complement 13-bit values. Results below the smallest normal exponent, such as -1100, are reported without wrapping.
- R10: Outputs update on the clock edge after `in_valid`, with `out_valid` high for exactly that cycle. Synchronous reset clears `out_valid` and all result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| rdn | input | 1 | Rounding toward minus infinity selected (sign of exact zero) |
| p_sign | input | 1 | Product sign |
| p_exp | input | 13 | Product exponent, signed, unbiased |
| p_sig | input | 128 | Product significand, leading one at bit 126 |
| a_sign | input | 1 | Addend sign |
| a_exp | input | 13 | Addend exponent, signed, unbiased |
| a_sig | input | 53 | Addend significand with explicit leading one at bit 52 |
| a_zero | input | 1 | Addend is zero |
| out_valid | output | 1 | Result valid |
| r_sign | output | 1 | Result sign |
| r_exp | output | 13 | Result exponent, signed |
| r_sig | output | 56 | Result significand, leading one at bit 55, low three bits guard/round/sticky |
| r_zero | output | 1 | Exact-zero result |

## Verification
The bench builds the block with `OUT_REG = 1`, the registered variant, so each strobe gives a one-cycle result that the scoreboard can line up with its queue. The 13-bit exponent width lets directed cases push results below -1022 and use alignment distances of 64, 127, 128 and several hundred, which covers every branch of the sticky shifter. Random cases whose addend copies the top 53 product bits, with equal exponents and opposite signs, reach deep cancellations and exact zeros that uniform random inputs would almost never hit.

// File: rtl/fma_an_pkg.sv
package fma_an_pkg;

    localparam int WORK_W   = 128;
    localparam int LEAD_POS = 126;
    localparam int ADD_W    = 53;
    localparam int OUT_W    = 56;
    localparam int EXP_W    = 13;
    localparam int SH_W     = 8;
    localparam int ADD_SH   = LEAD_POS - (ADD_W - 1);
    localparam int RED_SH   = LEAD_POS - (OUT_W - 1);
    localparam int POS_W    = $clog2(WORK_W);
    localparam int SH_MAX   = (1 << SH_W) - 1;

    typedef logic [WORK_W-1:0]       wide_t;
    typedef logic signed [EXP_W-1:0] exp_t;
    typedef logic [SH_W-1:0]         shamt_t;
    typedef logic [POS_W-1:0]        pos_t;

    typedef struct packed {
        logic  sgn;
        exp_t  ex;
        wide_t mag;
    } sum_t;

    typedef struct packed {
        logic             sgn;
        exp_t             ex;
        logic [OUT_W-1:0] sig;
        logic             zero;
    } res_t;

    // Right shift where every discarded bit is folded into bit 0.
    function automatic wide_t sticky_shr(wide_t x, shamt_t n);
        wide_t r;
        wide_t lost_mask;
        if (int'(n) >= WORK_W) begin
            r    = '0;
            r[0] = |x;
        end else begin
            lost_mask = (wide_t'(1) << n) - wide_t'(1);
            r         = x >> n;
            r[0]      = r[0] | (|(x & lost_mask));
        end
        return r;
    endfunction

    // Priority encoder: index of the most significant set bit.
    function automatic pos_t lead_one(wide_t x);
        pos_t p;
        p = '0;
        for (int i = 0; i < WORK_W; i++) begin
            if (x[i]) p = pos_t'(i);
        end
        return p;
    endfunction

    function automatic shamt_t clamp_shift(logic [EXP_W:0] d);
        shamt_t s;
        if (d > (EXP_W+1)'(SH_MAX)) s = '1;
        else                        s = d[SH_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/fma_an_align.sv
module fma_an_align
    import fma_an_pkg::*;
(
    input  exp_t              p_exp,
    input  wide_t             p_sig,
    input  exp_t              a_exp,
    input  logic [ADD_W-1:0]  a_sig,
    output wide_t             p_al,
    output wide_t             a_al,
    output exp_t              e_com
);

    wide_t                  a_wide;
    logic signed [EXP_W:0]  d;
    logic [EXP_W:0]         dmag;
    logic                   a_big;
    shamt_t                 amt;

    always_comb begin
        a_wide = wide_t'(a_sig) << ADD_SH;
        d      = $signed({a_exp[EXP_W-1], a_exp}) - $signed({p_exp[EXP_W-1], p_exp});
        a_big  = d > 0;
        dmag   = a_big ? $unsigned(d) : $unsigned(-d);
        amt    = clamp_shift(dmag);
        if (a_big) begin
            p_al  = sticky_shr(p_sig, amt);
            a_al  = a_wide;
            e_com = a_exp;
        end else begin
            p_al  = p_sig;
            a_al  = sticky_shr(a_wide, amt);
            e_com = p_exp;
        end
        // R2: common exponent is never below either input exponent
        p_exp_common_r2: assert (e_com >= p_exp && e_com >= a_exp);
        // R2: a sticky right shift never grows an operand
        p_shift_shrinks_r2: assert (p_al <= p_sig && a_al <= a_wide);
    end

endmodule

// File: rtl/fma_an_combine.sv
module fma_an_combine
    import fma_an_pkg::*;
(
    input  logic  p_sign,
    input  logic  a_sign,
    input  wide_t p_al,
    input  wide_t a_al,
    input  exp_t  e_com,
    output sum_t  sum
);

    wide_t tot;
    logic  same;
    logic  a_ge;

    always_comb begin
        same = (p_sign == a_sign);
        a_ge = (a_al >= p_al);
        tot  = a_al + p_al;
        if (same) begin
            sum.sgn = a_sign;
            if (tot[WORK_W-1]) begin
                sum.mag = sticky_shr(tot, shamt_t'(1));
                sum.ex  = e_com + exp_t'(1);
            end else begin
                sum.mag = tot;
                sum.ex  = e_com;
            end
        end else begin
            sum.ex = e_com;
            if (a_ge) begin
                sum.mag = a_al - p_al;
                sum.sgn = a_sign;
            end else begin
                sum.mag = p_al - a_al;
                sum.sgn = p_sign;
            end
        end
        // R3: the 128-bit sum of two sub-2^127 values cannot wrap
        p_no_wrap_r3: assert (!same || (tot >= a_al && tot >= p_al));
        // R4: the difference never exceeds the larger magnitude
        p_sub_bounded_r4: assert (same || sum.mag <= (a_ge ? a_al : p_al));
    end

endmodule

// File: rtl/fma_an_norm.sv
module fma_an_norm
    import fma_an_pkg::*;
(
    input  sum_t  s,
    input  logic  rdn,
    output res_t  r
);

    pos_t  pos;
    pos_t  shift;
    wide_t norm;
    wide_t red;

    always_comb begin
        pos   = lead_one(s.mag);
        shift = pos_t'(LEAD_POS) - pos;
        norm  = s.mag << shift;
        red   = sticky_shr(norm, shamt_t'(RED_SH));
        if (s.mag == '0) begin
            r.sgn  = rdn;
            r.ex   = '0;
            r.sig  = '0;
            r.zero = 1'b1;
        end else begin
            r.sgn  = s.sgn;
            r.ex   = s.ex - exp_t'(shift);
            r.sig  = red[OUT_W-1:0];
            r.zero = 1'b0;
        end
        // R6: the incoming magnitude never reaches bit 127
        p_no_top_bit_r6: assert (s.mag[WORK_W-1] == 1'b0);
        // R8: narrowing leaves nothing above the 56-bit field
        p_reduced_fits_r8: assert (red[WORK_W-1:OUT_W] == '0);
    end

endmodule

// File: rtl/fma_sig_add_norm.sv
module fma_sig_add_norm
    import fma_an_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    rdn,
    input  logic                    p_sign,
    input  logic signed [EXP_W-1:0] p_exp,
    input  logic [WORK_W-1:0]       p_sig,
    input  logic                    a_sign,
    input  logic signed [EXP_W-1:0] a_exp,
    input  logic [ADD_W-1:0]        a_sig,
    input  logic                    a_zero,
    output logic                    out_valid,
    output logic                    r_sign,
    output logic signed [EXP_W-1:0] r_exp,
    output logic [OUT_W-1:0]        r_sig,
    output logic                    r_zero
);

    wide_t p_al;
    wide_t a_al;
    exp_t  e_com;
    sum_t  comb_sum;
    sum_t  sel_sum;
    res_t  nxt;
    res_t  cur;

    fma_an_align u_align (
        .p_exp (p_exp),
        .p_sig (p_sig),
        .a_exp (a_exp),
        .a_sig (a_sig),
        .p_al  (p_al),
        .a_al  (a_al),
        .e_com (e_com)
    );

    fma_an_combine u_combine (
        .p_sign (p_sign),
        .a_sign (a_sign),
        .p_al   (p_al),
        .a_al   (a_al),
        .e_com  (e_com),
        .sum    (comb_sum)
    );

    always_comb begin
        if (a_zero) begin
            sel_sum.sgn = p_sign;
            sel_sum.ex  = p_exp;
            sel_sum.mag = p_sig;
        end else begin
            sel_sum = comb_sum;
        end
    end

    fma_an_norm u_norm (
        .s   (sel_sum),
        .rdn (rdn),
        .r   (nxt)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    cur       <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) cur <= nxt;
                end
            end

            p_latency_r10: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            p_idle_r10: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
        end else begin : g_comb
            assign out_valid = in_valid;
            assign cur       = nxt;
        end
    endgenerate

    assign r_sign = cur.sgn;
    assign r_exp  = cur.ex;
    assign r_sig  = cur.sig;
    assign r_zero = cur.zero;

    p_lead_bit_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !r_zero) |-> r_sig[OUT_W-1]);
    p_zero_clean_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && r_zero) |-> (r_sig == '0 && r_exp == '0));

endmodule

// File: tb/fma_sig_add_norm_tb_top.sv
`timescale 1ns/1ps
module fma_sig_add_norm_tb_top;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid, rdn, p_sign, a_sign, a_zero;
    logic signed [12:0] p_exp, a_exp;
    logic [127:0]       p_sig;
    logic [52:0]        a_sig;
    logic               out_valid, r_sign, r_zero;
    logic signed [12:0] r_exp;
    logic [55:0]        r_sig;

    always #2 clk = ~clk;

    fma_sig_add_norm #(.OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .rdn(rdn),
        .p_sign(p_sign), .p_exp(p_exp), .p_sig(p_sig),
        .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig), .a_zero(a_zero),
        .out_valid(out_valid), .r_sign(r_sign), .r_exp(r_exp),
        .r_sig(r_sig), .r_zero(r_zero)
    );

    typedef struct packed {
        logic               sgn;
        logic signed [12:0] ex;
        logic [55:0]        sg;
        logic               zr;
    } exp_res_t;

    exp_res_t exq[$];
    string    tagq[$];
    int       nchk = 0;
    int       nfail = 0;
    bit       done = 0;

    function automatic logic [127:0] ref_shr(logic [127:0] x, int n);
        logic st = 1'b0;
        for (int i = 0; i < n && i < 130; i++) begin
            st = st | x[0];
            x  = x >> 1;
        end
        x[0] = x[0] | st;
        return x;
    endfunction

    function automatic exp_res_t ref_model(logic ps, int pe, logic [127:0] psig,
                                           logic as_, int ae, logic [52:0] asig,
                                           logic az, logic rd);
        exp_res_t     r;
        logic [127:0] aw, m, t;
        int           e;
        logic         s;
        if (az) begin
            t = ref_shr(psig, 71);
            r = '{ps, 13'(pe), t[55:0], 1'b0};
            return r;
        end
        aw = {75'd0, asig} << 74;
        if (ae > pe) begin psig = ref_shr(psig, ae - pe); e = ae; end
        else begin aw = ref_shr(aw, pe - ae); e = pe; end
        if (ps == as_) begin
            m = aw + psig; s = as_;
            if (m[127]) begin m = ref_shr(m, 1); e++; end
        end else if (aw >= psig) begin
            m = aw - psig; s = as_;
        end else begin
            m = psig - aw; s = ps;
        end
        if (m == 0) begin
            r = '{rd, 13'sd0, 56'd0, 1'b1};
            return r;
        end
        while (!m[126]) begin m = m << 1; e--; end
        t = ref_shr(m, 71);
        r = '{s, 13'(e), t[55:0], 1'b0};
        return r;
    endfunction

    task automatic drive(input string tag, input logic ps, input int pe,
                         input logic [127:0] psig, input logic as_, input int ae,
                         input logic [52:0] asig, input logic az, input logic rd);
        @(negedge clk);
        exq.push_back(ref_model(ps, pe, psig, as_, ae, asig, az, rd));
        tagq.push_back(tag);
        in_valid = 1'b1; rdn = rd; a_zero = az;
        p_sign = ps; p_exp = 13'(pe); p_sig = psig;
        a_sign = as_; a_exp = 13'(ae); a_sig = asig;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_res_t e;
            string    tg;
            nchk++;
            if (exq.size() == 0) begin
                nfail++;
                $display("FAIL R10: out_valid with no pending item, got 1 expected 0");
            end else begin
                e  = exq.pop_front();
                tg = tagq.pop_front();
                if (r_sign !== e.sgn || r_exp !== e.ex || r_sig !== e.sg || r_zero !== e.zr) begin
                    nfail++;
                    $display("FAIL %s: got s=%0b e=%0d sig=%h z=%0b expected s=%0b e=%0d sig=%h z=%0b",
                             tg, r_sign, r_exp, r_sig, r_zero, e.sgn, e.ex, e.sg, e.zr);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
    end

    function automatic logic [127:0] rnd_prod();
        logic [127:0] v;
        v = {$urandom(), $urandom(), $urandom(), $urandom()};
        v[127] = 1'b0; v[126] = 1'b1;
        return v;
    endfunction

    localparam logic [127:0] ONE126 = 128'd1 << 126;
    localparam logic [52:0]  ONE52  = 53'd1 << 52;

    initial begin
        rst = 1'b1; in_valid = 0; rdn = 0; a_zero = 0;
        p_sign = 0; p_exp = 0; p_sig = 0; a_sign = 0; a_exp = 0; a_sig = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R10: reset state
        nchk++;
        if (out_valid !== 1'b0 || r_sig !== 56'd0 || r_zero !== 1'b0) begin
            nfail++;
            $display("FAIL R10: reset state got v=%0b sig=%h expected v=0 sig=0", out_valid, r_sig);
        end

        // R3: 1.0 + 1.0 carries into bit 127
        drive("R3", 0, 0, ONE126, 0, 0, ONE52, 0, 0);
        drive("R3", 1, 5, rnd_prod(), 1, 5, ONE52 | 53'h1_2345_6789, 0, 0);
        // R1: tiny product under an addend with low bit set
        drive("R1", 0, -200, ONE126, 0, 0, ONE52 | 53'd1, 0, 0);
        // R2: product shifted by 64, 127, 128, 300; addend shifted by 2
        drive("R2", 0, 0, ONE126 | 128'hFFFF, 0, 64, ONE52, 0, 0);
        drive("R2", 0, 0, rnd_prod(), 0, 127, ONE52, 0, 0);
        drive("R2", 0, 0, rnd_prod(), 1, 128, ONE52, 0, 0);
        drive("R2", 1, 0, rnd_prod(), 0, 300, ONE52 | 53'd7, 0, 0);
        drive("R2", 0, 10, rnd_prod(), 0, 8, ONE52 | 53'd3, 0, 0);
        // R4: product larger takes product sign; addend larger takes addend sign
        drive("R4", 1, 3, ONE126, 0, 1, ONE52, 0, 0);
        drive("R4", 0, 0, ONE126, 1, 2, ONE52, 0, 0);
        // R5: exact cancellation, both rounding directions
        drive("R5", 0, 7, ONE126, 1, 7, ONE52, 0, 0);
        drive("R5", 1, 7, ONE126, 0, 7, ONE52, 0, 1);
        // R6: deep cancellation leaving bit 0, bit 63, bit 64
        drive("R6", 0, 0, ONE126 | 128'd1, 1, 0, ONE52, 0, 0);
        drive("R6", 0, 0, ONE126 | (128'd1 << 63), 1, 0, ONE52, 0, 0);
        drive("R6", 1, 4, ONE126 | (128'd1 << 64) | 128'd5, 0, 4, ONE52, 0, 0);
        // R7: zero addend, addend fields and rdn irrelevant
        drive("R7", 1, -33, rnd_prod(), 0, 900, ONE52 | 53'd9, 1, 1);
        // R8: sticky narrowing of discarded low bits
        drive("R8", 0, 2, ONE126 | 128'd1, 0, 0, 53'd0, 1, 0);
        // R9: result far below the smallest normal exponent
        drive("R9", 0, -1000, ONE126 | 128'd1, 1, -1000, ONE52, 0, 0);

        for (int k = 0; k < 300; k++) begin
            logic [127:0] ps_v;
            int pe_v, ae_v;
            ps_v = rnd_prod();
            pe_v = int'($urandom_range(0, 2000)) - 1000;
            if (k % 3 == 0) begin
                drive("R6 cancel", 0, pe_v, ps_v, 1, pe_v, ps_v[126:74], 0, k[0]);
            end else begin
                ae_v = pe_v + int'($urandom_range(0, 140)) - 70;
                drive("R4 random", $urandom_range(0, 1), pe_v, ps_v, $urandom_range(0, 1),
                      ae_v, ONE52 | 53'($urandom()), 0, k[1]);
            end
        end
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R10: no result without a strobe, and nothing left pending
        nchk++;
        if (out_valid !== 1'b0 || exq.size() != 0) begin
            nfail++;
            $display("FAIL R10: idle got v=%0b pending=%0d expected v=0 pending=0", out_valid, exq.size());
        end
        summary();
    end

endmodule